// File: doc/BRIEF.md
# Debug Command Launch and Channel Interrupt Front End

This block is the register-mapped control front end of a multi-channel DMA engine. Software uses it to start or kill a channel. It writes an encoded instruction into two staging words. A write of zero to a trigger register then fires the instruction. The block holds a single issue request toward the channels, made up of the target channel number, an opcode and a 32-bit operand. This request stays up until the addressed channel acknowledges it. A status bit reports that a command is still in flight, so software polls it before it stages the next command.

The same front end also collects one completion event line per channel. Each event sets a sticky raw bit. The raw bits are qualified by a per-channel enable mask, and the block drives a single interrupt line that is high while any qualified bit is set. Software clears raw bits by writing ones to a clear register. The current state nibble of each channel can also be read through the register bus. All bus reads return data one cycle after the request.

Top module: `dbgl_ctrl`

## Requirements
- R1: After synchronous reset, the busy bit (bit 0 at 0xD00) reads 0, the enable and raw registers read 0, `iss_valid` is 0 and `irq` is 0.
- R2: Staging word 0 (0xD08) and staging word 1 (0xD0C) are read/write and return the last value written.
- R3: A start command is staged as word 0 with 0xA0 in bits 23:16 and the channel number plus one in bits 15:8. A write of 0 to 0xD04 then raises `iss_valid` and the busy bit in the next cycle. In that cycle `iss_chan` is the channel, `iss_opcode` is 0xA0 and `iss_operand` is staging word 1.
- R4: A kill command is staged as word 0 with 0x01 in bits 7:0 and the channel number plus one in bits 15:8. It issues with `iss_opcode` 0x01 and `iss_operand` 0. When bits 7:0 hold 0x01, the command is a kill whatever bits 23:16 hold.
- R5: An acknowledge on `ch_ack[iss_chan]` clears `iss_valid` and the busy bit after that clock edge. An acknowledge from any other channel has no effect.
- R6: A trigger write while busy is ignored: no new issue, and the issue fields stay unchanged.
- R7: A trigger write does not issue if the channel field is 0 or greater than NCH, if no known opcode is present, or if the write data is nonzero.
- R8: The enable register at 0x020 holds NCH bits, one per channel. Bits above NCH read 0.
- R9: A pulse on `ch_event[i]` sets raw bit i (read at 0x024), and the bit stays set until it is cleared.
- R10: Writing 1 to bit i of 0x02C clears raw bit i, and zero bits leave their raw bits alone. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: Address 0x028 reads raw AND enable. `irq` is the OR of those masked bits.
- R12: Address 0x100 + 8*n reads the 4-bit state of channel n in bits 3:0, with the upper bits 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ch_state | input | NCH*4 | Packed per-channel state nibbles |
| ch_event | input | NCH | Per-channel event pulses |
| ch_ack | input | NCH | Per-channel issue acknowledge |
| iss_valid | output | 1 | Issue request held until acknowledged |
| iss_chan | output | $clog2(NCH) | Target channel |
| iss_opcode | output | 8 | Instruction opcode |
| iss_operand | output | 32 | Program address for start, 0 for kill |
| irq | output | 1 | OR of the masked event bits |

## Verification
The assertions assume that a channel only acknowledges while an issue request is up. They also assume that events arrive as single-cycle pulses, and that the bus changes only between clock edges. The stimulus respects this. It raises `ch_ack` and `ch_event` for exactly one cycle, away from the active edge. It acknowledges only after it has observed the request, or deliberately from a non-target channel to test R5. NCH is kept at its default of 8, within the 2 to 32 range that the status address window allows.

// File: rtl/dbgl_pkg.sv
`timescale 1ns/1ps
package dbgl_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFF_IRQ_EN   = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_IRQ_RAW  = 12'h024;
    localparam logic [ADDR_W-1:0] OFF_IRQ_MSK  = 12'h028;
    localparam logic [ADDR_W-1:0] OFF_IRQ_CLR  = 12'h02C;
    localparam logic [ADDR_W-1:0] OFF_DBG_STAT = 12'hD00;
    localparam logic [ADDR_W-1:0] OFF_DBG_CMD  = 12'hD04;
    localparam logic [ADDR_W-1:0] OFF_DBG_W0   = 12'hD08;
    localparam logic [ADDR_W-1:0] OFF_DBG_W1   = 12'hD0C;
    localparam logic [3:0]        CHST_PAGE    = 4'h1;

    // Opcodes
    localparam logic [7:0] OP_START = 8'hA0;
    localparam logic [7:0] OP_KILL  = 8'h01;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_IRQ_EN,
        RS_IRQ_RAW,
        RS_IRQ_MSK,
        RS_DBG_STAT,
        RS_DBG_W0,
        RS_DBG_W1,
        RS_CHST
    } rsel_e;

    typedef struct packed {
        logic en_wr;
        logic clr_wr;
        logic cmd_wr;
        logic w0_wr;
        logic w1_wr;
    } wstb_t;

    typedef struct packed {
        logic       ok;
        logic [7:0] chan_p1;
        logic [7:0] opcode;
    } dcd_t;

    // Kill byte in the low lane takes precedence over a start byte in lane 2
    function automatic dcd_t decode_w0(input logic [DATA_W-1:0] w0);
        dcd_t d;
        d.chan_p1 = w0[15:8];
        if (w0[7:0] == OP_KILL) begin
            d.ok     = 1'b1;
            d.opcode = OP_KILL;
        end else if (w0[23:16] == OP_START) begin
            d.ok     = 1'b1;
            d.opcode = OP_START;
        end else begin
            d.ok     = 1'b0;
            d.opcode = 8'h00;
        end
        return d;
    endfunction

endpackage

// File: rtl/dbgl_busdec.sv
`timescale 1ns/1ps
module dbgl_busdec
    import dbgl_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output wstb_t             wstb,
    output rsel_e             rsel,
    output logic [4:0]        ch_idx
);

    logic in_chst;

    always_comb begin
        in_chst = (bus_addr[11:8] == CHST_PAGE) && (bus_addr[2:0] == 3'b000)
                  && (int'(bus_addr[7:3]) < int'(NCH));
    end

    always_comb begin
        wstb   = '0;
        rsel   = RS_NONE;
        ch_idx = bus_addr[7:3];
        if (bus_sel && bus_wr) begin
            case (bus_addr)
                OFF_IRQ_EN:  wstb.en_wr  = 1'b1;
                OFF_IRQ_CLR: wstb.clr_wr = 1'b1;
                OFF_DBG_CMD: wstb.cmd_wr = (bus_wdata == '0);
                OFF_DBG_W0:  wstb.w0_wr  = 1'b1;
                OFF_DBG_W1:  wstb.w1_wr  = 1'b1;
                default:     wstb        = '0;
            endcase
        end else if (bus_sel) begin
            case (bus_addr)
                OFF_IRQ_EN:   rsel = RS_IRQ_EN;
                OFF_IRQ_RAW:  rsel = RS_IRQ_RAW;
                OFF_IRQ_MSK:  rsel = RS_IRQ_MSK;
                OFF_DBG_STAT: rsel = RS_DBG_STAT;
                OFF_DBG_W0:   rsel = RS_DBG_W0;
                OFF_DBG_W1:   rsel = RS_DBG_W1;
                default:      rsel = in_chst ? RS_CHST : RS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dbgl_launch.sv
`timescale 1ns/1ps
module dbgl_launch
    import dbgl_pkg::*;
#(
    parameter int unsigned NCH = 8,
    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  wstb_t             wstb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NCH-1:0]    ch_ack,
    output logic [DATA_W-1:0] w0_q,
    output logic [DATA_W-1:0] w1_q,
    output logic              busy_q,
    output logic [CW-1:0]     chan_q,
    output logic [7:0]        op_q,
    output logic [DATA_W-1:0] opd_q
);

    dcd_t dcd;
    logic chan_ok;
    logic fire;
    logic done;

    always_comb begin
        dcd     = decode_w0(w0_q);
        chan_ok = (dcd.chan_p1 != 8'd0) && (int'(dcd.chan_p1) <= int'(NCH));
        fire    = wstb.cmd_wr && !busy_q && dcd.ok && chan_ok;
        done    = busy_q && ch_ack[chan_q];
    end

    // Staging words
    always_ff @(posedge clk) begin
        if (rst) begin
            w0_q <= '0;
            w1_q <= '0;
        end else begin
            if (wstb.w0_wr) w0_q <= wdata;
            if (wstb.w1_wr) w1_q <= wdata;
        end
    end

    // Issue request, held until the target acknowledges
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            chan_q <= '0;
            op_q   <= 8'h00;
            opd_q  <= '0;
        end else if (fire) begin
            busy_q <= 1'b1;
            chan_q <= CW'(dcd.chan_p1 - 8'd1);
            op_q   <= dcd.opcode;
            opd_q  <= (dcd.opcode == OP_KILL) ? '0 : w1_q;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dbgl_irqbank.sv
`timescale 1ns/1ps
module dbgl_irqbank
    import dbgl_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  wstb_t             wstb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NCH-1:0]    ch_event,
    output logic [NCH-1:0]    en_q,
    output logic [NCH-1:0]    raw_q,
    output logic [NCH-1:0]    masked,
    output logic              irq
);

    logic [NCH-1:0] clr_bits;
    logic [NCH-1:0] raw_nxt;

    always_comb begin
        clr_bits = wstb.clr_wr ? wdata[NCH-1:0] : '0;
        raw_nxt  = (raw_q & ~clr_bits) | ch_event;   // set wins over clear
        masked   = raw_q & en_q;
        irq      = |masked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            raw_q <= '0;
        end else begin
            if (wstb.en_wr) en_q <= wdata[NCH-1:0];
            raw_q <= raw_nxt;
        end
    end

endmodule

// File: rtl/dbgl_ctrl.sv
`timescale 1ns/1ps
module dbgl_ctrl
    import dbgl_pkg::*;
#(
    parameter int unsigned NCH = 8,
    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH*4-1:0]  ch_state,
    input  logic [NCH-1:0]    ch_event,
    input  logic [NCH-1:0]    ch_ack,
    output logic              iss_valid,
    output logic [CW-1:0]     iss_chan,
    output logic [7:0]        iss_opcode,
    output logic [DATA_W-1:0] iss_operand,
    output logic              irq
);

    wstb_t             wstb;
    rsel_e             rsel;
    logic [4:0]        ch_idx;
    logic [DATA_W-1:0] w0_w;
    logic [DATA_W-1:0] w1_w;
    logic              busy_w;
    logic [NCH-1:0]    en_w;
    logic [NCH-1:0]    raw_w;
    logic [NCH-1:0]    msk_w;
    logic [3:0]        st_sel;
    logic [DATA_W-1:0] rd_nxt;

    dbgl_busdec #(.NCH(NCH)) u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wstb      (wstb),
        .rsel      (rsel),
        .ch_idx    (ch_idx)
    );

    dbgl_launch #(.NCH(NCH)) u_launch (
        .clk    (clk),
        .rst    (rst),
        .wstb   (wstb),
        .wdata  (bus_wdata),
        .ch_ack (ch_ack),
        .w0_q   (w0_w),
        .w1_q   (w1_w),
        .busy_q (busy_w),
        .chan_q (iss_chan),
        .op_q   (iss_opcode),
        .opd_q  (iss_operand)
    );

    dbgl_irqbank #(.NCH(NCH)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .wstb     (wstb),
        .wdata    (bus_wdata),
        .ch_event (ch_event),
        .en_q     (en_w),
        .raw_q    (raw_w),
        .masked   (msk_w),
        .irq      (irq)
    );

    assign iss_valid = busy_w;

    // Channel state nibble selection
    always_comb begin
        st_sel = 4'h0;
        for (int i = 0; i < int'(NCH); i++) begin
            if (int'(ch_idx) == i) st_sel = ch_state[i*4 +: 4];
        end
    end

    always_comb begin
        case (rsel)
            RS_IRQ_EN:   rd_nxt = DATA_W'(en_w);
            RS_IRQ_RAW:  rd_nxt = DATA_W'(raw_w);
            RS_IRQ_MSK:  rd_nxt = DATA_W'(msk_w);
            RS_DBG_STAT: rd_nxt = DATA_W'(busy_w);
            RS_DBG_W0:   rd_nxt = w0_w;
            RS_DBG_W1:   rd_nxt = w1_w;
            RS_CHST:     rd_nxt = DATA_W'(st_sel);
            default:     rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                    bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_nxt;
    end

endmodule

// File: rtl/dbgl_ctrl_chk.sv
`timescale 1ns/1ps
module dbgl_ctrl_chk
    import dbgl_pkg::*;
#(
    parameter int unsigned NCH = 8,
    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    ch_event,
    input logic [NCH-1:0]    ch_ack,
    input logic              iss_valid,
    input logic [CW-1:0]     iss_chan,
    input logic [7:0]        iss_opcode,
    input logic [DATA_W-1:0] iss_operand,
    input logic              irq,
    input logic [NCH-1:0]    en_w,
    input logic [NCH-1:0]    raw_w
);

    // R5: request persists until its own channel acknowledges
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !ch_ack[iss_chan]) |=> iss_valid);

    // R5: acknowledge from the target drops the request
    a_r5_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && ch_ack[iss_chan]) |=> !iss_valid);

    // R6: issue fields frozen while the request is up
    a_r6_fields_stable: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> (!iss_valid || ($stable(iss_chan) && $stable(iss_opcode)
                                      && $stable(iss_operand))));

    // R3: only known opcodes are ever issued
    a_r3_legal_op: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (iss_opcode == OP_START || iss_opcode == OP_KILL));

    // R4: kill carries a zero operand
    a_r4_kill_zero: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_opcode == OP_KILL) |-> (iss_operand == '0));

    // R11: no interrupt with every channel masked
    a_r11_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (en_w == '0) |-> !irq);

    // R9: each event leaves its raw bit set
    for (genvar g = 0; g < int'(NCH); g++) begin : g_evt
        a_r9_event_sets: assert property (@(posedge clk) disable iff (rst)
            ch_event[g] |=> raw_w[g]);
    end

endmodule

bind dbgl_ctrl dbgl_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ch_event    (ch_event),
    .ch_ack      (ch_ack),
    .iss_valid   (iss_valid),
    .iss_chan    (iss_chan),
    .iss_opcode  (iss_opcode),
    .iss_operand (iss_operand),
    .irq         (irq),
    .en_w        (en_w),
    .raw_w       (raw_w)
);

// File: tb/dbgl_ctrl_tb.sv
`timescale 1ns/1ps
module dbgl_ctrl_tb;

    localparam int NCH = 8;
    localparam int CW  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH*4-1:0]  ch_state = '0;
    logic [NCH-1:0]    ch_event = '0;
    logic [NCH-1:0]    ch_ack = '0;
    logic              iss_valid;
    logic [CW-1:0]     iss_chan;
    logic [7:0]        iss_opcode;
    logic [31:0]       iss_operand;
    logic              irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int          chan;
        int          op;
        logic [31:0] opd;
    } iss_exp_t;

    iss_exp_t    iss_q[$];
    logic [31:0] rd_q[$];
    string       rdtag_q[$];
    bit          rd_chk = 1'b0;
    bit          prev_v = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dbgl_ctrl #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_state(ch_state), .ch_event(ch_event), .ch_ack(ch_ack),
        .iss_valid(iss_valid), .iss_chan(iss_chan), .iss_opcode(iss_opcode),
        .iss_operand(iss_operand), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        rd_q.push_back(exp);
        rdtag_q.push_back(tag);
        @(posedge clk);
        #1 rd_chk = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic expect_issue(input int c, input int op, input logic [31:0] opd);
        iss_exp_t e;
        e.chan = c; e.op = op; e.opd = opd;
        iss_q.push_back(e);
    endtask

    task automatic pulse_ack(input int c);
        @(negedge clk);
        ch_ack = '0; ch_ack[c] = 1'b1;
        @(negedge clk);
        ch_ack = '0;
    endtask

    task automatic pulse_evt(input logic [NCH-1:0] m);
        @(negedge clk);
        ch_event = m;
        @(negedge clk);
        ch_event = '0;
    endtask

    // Monitor: read data and issue scoreboard
    always @(negedge clk) begin
        if (rd_chk) begin
            rd_chk = 1'b0;
            if (rd_q.size() > 0) begin
                chk(rdtag_q.pop_front(), bus_rdata, rd_q.pop_front());
            end
        end
        if (!rst && iss_valid && !prev_v) begin
            checks++;
            if (iss_q.size() == 0) begin
                errors++;
                $display("FAIL R6/R7 unexpected issue: actual chan %0d op %h expected none",
                         iss_chan, iss_opcode);
            end else begin
                iss_exp_t e;
                e = iss_q.pop_front();
                if (int'(iss_chan) != e.chan || int'(iss_opcode) != e.op || iss_operand !== e.opd) begin
                    errors++;
                    $display("FAIL R3/R4 issue: actual %0d/%h/%h expected %0d/%h/%h",
                             iss_chan, iss_opcode, iss_operand, e.chan, e.op[7:0], e.opd);
                end
            end
        end
        prev_v = iss_valid;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) ch_state[i*4 +: 4] = 4'((i * 5 + 3) % 16);
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk("R1 iss_valid", 32'(iss_valid), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(12'hD00, 0, "R1 busy");
        rd(12'h020, 0, "R1 enable");
        rd(12'h024, 0, "R1 raw");

        // R2 staging
        wr(12'hD08, 32'h00A0_0400);
        wr(12'hD0C, 32'h1234_5678);
        rd(12'hD08, 32'h00A0_0400, "R2 word0");
        rd(12'hD0C, 32'h1234_5678, "R2 word1");

        // R3 start channel 3
        expect_issue(3, 8'hA0, 32'h1234_5678);
        wr(12'hD04, 0);
        chk("R3 iss_valid", 32'(iss_valid), 1);
        rd(12'hD00, 1, "R3 busy");

        // R6 trigger while busy ignored
        wr(12'hD08, 32'h0000_0101);
        wr(12'hD04, 0);
        chk("R6 chan unchanged", 32'(iss_chan), 3);
        chk("R6 opcode unchanged", 32'(iss_opcode), 32'hA0);
        rd(12'hD08, 32'h0000_0101, "R2 word0 rewrite");

        // R5 foreign ack, then target ack
        pulse_ack(5);
        rd(12'hD00, 1, "R5 foreign ack ignored");
        pulse_ack(3);
        chk("R5 valid dropped", 32'(iss_valid), 0);
        rd(12'hD00, 0, "R5 busy cleared");

        // R4 kill channel 0 (word0 = 0x101)
        expect_issue(0, 8'h01, 0);
        wr(12'hD04, 0);
        chk("R4 iss_valid", 32'(iss_valid), 1);
        pulse_ack(0);

        // R4 kill wins over start byte
        wr(12'hD08, 32'h00A0_0201);
        expect_issue(1, 8'h01, 0);
        wr(12'hD04, 0);
        pulse_ack(1);

        // R7 rejected triggers
        wr(12'hD08, 32'h00A0_0000);
        wr(12'hD04, 0);
        rd(12'hD00, 0, "R7 channel field zero");
        wr(12'hD08, 32'h00A0_0900);
        wr(12'hD04, 0);
        rd(12'hD00, 0, "R7 channel above range");
        wr(12'hD08, 32'h0055_0200);
        wr(12'hD04, 0);
        rd(12'hD00, 0, "R7 unknown opcode");
        wr(12'hD08, 32'h00A0_0800);
        wr(12'hD04, 1);
        rd(12'hD00, 0, "R7 nonzero trigger data");
        expect_issue(7, 8'hA0, 32'h1234_5678);
        wr(12'hD04, 0);
        rd(12'hD00, 1, "R3 last channel busy");
        pulse_ack(7);

        // R8 enable
        wr(12'h020, 32'hFFFF_FF05);
        rd(12'h020, 32'h05, "R8 enable width");
        chk("R11 irq idle", 32'(irq), 0);

        // R9 / R11 events
        pulse_evt(8'h06);
        rd(12'h024, 32'h06, "R9 raw set");
        rd(12'h028, 32'h04, "R11 masked");
        chk("R11 irq high", 32'(irq), 1);
        rd(12'h024, 32'h06, "R9 raw sticky");

        // R10 clear
        wr(12'h02C, 32'h04);
        rd(12'h024, 32'h02, "R10 clear one bit");
        chk("R11 irq after clear", 32'(irq), 0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h02C; bus_wdata = 32'h08;
        ch_event = 8'h08;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ch_event = '0;
        rd(12'h024, 32'h0A, "R10 set wins");
        wr(12'h02C, 0);
        rd(12'h024, 32'h0A, "R10 zero write no effect");

        // R12 channel state
        rd(12'h100, 32'h3, "R12 chan0 state");
        rd(12'h128, 32'((5 * 5 + 3) % 16), "R12 chan5 state");
        rd(12'h138, 32'((7 * 5 + 3) % 16), "R12 chan7 state");
        rd(12'h104, 0, "R12 unmapped odd word");
        rd(12'h040, 0, "R12 unmapped offset");

        // R11 full mask
        wr(12'h020, 32'hFF);
        rd(12'h028, 32'h0A, "R11 masked full");
        chk("R11 irq full", 32'(irq), 1);
        wr(12'h02C, 32'hFF);
        chk("R11 irq cleared", 32'(irq), 0);

        repeat (3) @(negedge clk);
        checks++;
        if (iss_q.size() != 0) begin
            errors++;
            $display("FAIL R3 missing issues: actual %0d pending expected 0", iss_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule